// File: doc/BRIEF.md
# Bit-Level Pipelined Adder

This block adds two 16-bit unsigned operands. It returns a 16-bit sum and a carry-out. The carry is resolved two bit positions at a time, in a chain of pipeline stages. Each stage holds the carry for its bit pair plus only the state that is still needed:

- the operand bits above the pair, which have not been added yet;
- the sum bits below it, which are already final.

Every bit position is a full-add built from two half-adder rows. The operand bits form a triangle that shrinks by two bits per stage. The finished sum bits form a triangle that grows by two bits per stage. Together these align all result bits at the last stage. No separate deskew row is needed.

One addition can start on every clock. A valid flag travels with the data through the same number of stages. A stage whose slot is empty keeps its data registers unchanged. As a result, the outputs hold the last result while bubbles pass through. With the default parameters the depth is 8 stages.

Top module: `bpa_pipe_adder`

## Requirements
- R1: An operand pair sampled with valid_i=1 at a rising edge appears as {cout_o, sum_o} = a_i + b_i (17-bit unsigned) after the 8th rising edge, counting the sampling edge as the first.
- R2: valid_o is high exactly when valid_i was high at the rising edge 8 edges earlier. Back-to-back pairs produce back-to-back results, one per clock.
- R3: cout_o carries bit 16 of the full sum. For example, 0xFFFF + 0x0001 gives sum_o = 0x0000 and cout_o = 1, with the carry crossing all 8 stages.
- R4: While rst_ni is low, valid_o, sum_o and cout_o are 0, whatever the clock or the inputs do.
- R5: A cycle with valid_i=0 has no effect on the outputs. When that slot reaches the output, sum_o and cout_o keep the value of the previous result, whatever a_i and b_i held.
- R6: Each addition's carry stays inside that addition. A carry-heavy pair followed at once by 0x0000 + 0x0000 still yields 0 with cout_o = 0 for the second pair.
- R7: Asserting rst_ni low while additions are in flight discards them all. After release, valid_o stays low until 8 edges after a new valid pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair on a_i/b_i is to be added |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| valid_o | output | 1 | sum_o/cout_o hold a new result |
| sum_o | output | 16 | Low 16 bits of the sum |
| cout_o | output | 1 | Carry out of bit 15 |

## Verification
Two events can fall in the same cycle: a result leaving the last stage, and a new pair entering stage 0. A long carry can also cross the stages of several overlapping additions at once. The bench provokes both overlaps by driving operand pairs back to back with no gaps, including all-ones plus one directly before zero plus zero. It also mixes in bubble cycles with all-ones operands, and an asynchronous reset that lands while the pipe is full. Each output cycle is judged against an 8-deep model of expected sums and valids built from the requirements. During bubble cycles the expected value is the last result delivered.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
  typedef struct packed {
    logic s;
    logic c;
  } ha_t;

  function automatic ha_t half_add(input logic a, input logic b);
    ha_t r;
    r.s = a ^ b;
    r.c = a & b;
    return r;
  endfunction
endpackage

// File: rtl/bpa_half_adder.sv
module bpa_half_adder
  import bpa_pkg::*;
(
  input  logic x_i,
  input  logic y_i,
  output logic s_o,
  output logic c_o
);
  ha_t r;
  assign r   = half_add(x_i, y_i);
  assign s_o = r.s;
  assign c_o = r.c;
endmodule

// File: rtl/bpa_bit_cell.sv
// One bit position: two half-adder rows merged.
module bpa_bit_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic s1, c1, c2;

  bpa_half_adder u_row0 (.x_i(a_i), .y_i(b_i), .s_o(s1),  .c_o(c1));
  bpa_half_adder u_row1 (.x_i(s1),  .y_i(c_i), .s_o(s_o), .c_o(c2));

  assign c_o = c1 | c2;
endmodule

// File: rtl/bpa_stage.sv
// Stage IDX resolves bits [IDX*BPS +: BPS]; keeps only upper operands and lower sums.
module bpa_stage #(
  parameter int unsigned W   = 16,
  parameter int unsigned BPS = 2,
  parameter int unsigned IDX = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         v_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] s_i,
  input  logic         c_i,
  output logic         v_o,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  localparam int unsigned LO = IDX * BPS;
  localparam int unsigned HI = LO + BPS;

  logic [BPS:0]   cy;
  logic [BPS-1:0] sb;
  logic [W-1:0]   a_nxt, b_nxt, s_nxt;

  assign cy[0] = c_i;

  for (genvar j = 0; j < BPS; j++) begin : g_bit
    if (LO + j < W) begin : g_live
      bpa_bit_cell u_cell (
        .a_i(a_i[LO+j]),
        .b_i(b_i[LO+j]),
        .c_i(cy[j]),
        .s_o(sb[j]),
        .c_o(cy[j+1])
      );
    end else begin : g_pad
      assign sb[j]   = 1'b0;
      assign cy[j+1] = cy[j];
    end
  end

  always_comb begin
    a_nxt = '0;
    b_nxt = '0;
    for (int i = 0; i < int'(W); i++) begin
      if (i >= int'(HI)) begin
        a_nxt[i] = a_i[i];
        b_nxt[i] = b_i[i];
      end
    end
  end

  always_comb begin
    s_nxt = s_i;
    for (int j = 0; j < int'(BPS); j++) begin
      if (int'(LO) + j < int'(W)) s_nxt[int'(LO)+j] = sb[j];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o <= 1'b0;
      a_o <= '0;
      b_o <= '0;
      s_o <= '0;
      c_o <= 1'b0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        a_o <= a_nxt;
        b_o <= b_nxt;
        s_o <= s_nxt;
        c_o <= cy[BPS];
      end
    end
  end
endmodule

// File: rtl/bpa_pipe_adder.sv
module bpa_pipe_adder #(
  parameter int unsigned WIDTH          = 16,
  parameter int unsigned BITS_PER_STAGE = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int unsigned STAGES  = (WIDTH + BITS_PER_STAGE - 1) / BITS_PER_STAGE;
  localparam int unsigned LATENCY = STAGES;

  logic [WIDTH-1:0] a_q [STAGES+1];
  logic [WIDTH-1:0] b_q [STAGES+1];
  logic [WIDTH-1:0] s_q [STAGES+1];
  logic [STAGES:0]  c_q;
  logic [STAGES:0]  v_q;

  assign a_q[0] = a_i;
  assign b_q[0] = b_i;
  assign s_q[0] = '0;
  assign c_q[0] = 1'b0;
  assign v_q[0] = valid_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    bpa_stage #(
      .W  (WIDTH),
      .BPS(BITS_PER_STAGE),
      .IDX(g)
    ) u_stg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .v_i   (v_q[g]),
      .a_i   (a_q[g]),
      .b_i   (b_q[g]),
      .s_i   (s_q[g]),
      .c_i   (c_q[g]),
      .v_o   (v_q[g+1]),
      .a_o   (a_q[g+1]),
      .b_o   (b_q[g+1]),
      .s_o   (s_q[g+1]),
      .c_o   (c_q[g+1])
    );
  end

  assign valid_o = v_q[STAGES];
  assign sum_o   = s_q[STAGES];
  assign cout_o  = c_q[STAGES];

  logic unused_tail;
  assign unused_tail = ^{a_q[STAGES], b_q[STAGES], LATENCY[0]};
endmodule

// File: rtl/bpa_pipe_adder_chk.sv
module bpa_pipe_adder_chk #(
  parameter int unsigned W   = 16,
  parameter int unsigned LAT = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         valid_o,
  input logic [W-1:0] sum_o,
  input logic         cout_o
);
  logic [W:0]     ref_s [LAT];
  logic [LAT-1:0] ref_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_v <= '0;
      for (int i = 0; i < int'(LAT); i++) ref_s[i] <= '0;
    end else begin
      ref_v    <= {ref_v[LAT-2:0], valid_i};
      ref_s[0] <= {1'b0, a_i} + {1'b0, b_i};
      for (int i = 1; i < int'(LAT); i++) ref_s[i] <= ref_s[i-1];
    end
  end

  assert_sum_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ({cout_o, sum_o} == ref_s[LAT-1]));

  // also covers R7: reference is flushed by the same reset
  assert_valid_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == ref_v[LAT-1]);

  assert_cout_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cout_o == ref_s[LAT-1][W]));

  assert_reset_quiet_R4: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && sum_o == '0 && !cout_o));

  assert_bubble_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(sum_o) && $stable(cout_o)));
endmodule

bind bpa_pipe_adder bpa_pipe_adder_chk #(.W(WIDTH), .LAT(LATENCY)) u_chk (.*);

// File: tb/sim_bpa_pipe_adder.sv
`timescale 1ns/1ps
module sim_bpa_pipe_adder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] a_i = '0, b_i = '0;
  logic        valid_o;
  logic [15:0] sum_o;
  logic        cout_o;

  int n_run = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  bpa_pipe_adder u0 (.*);

  // {a, b, expected 17-bit sum}
  localparam int NV = 10;
  localparam logic [48:0] TBL [NV] = '{
    {16'hFFFF, 16'h0001, 17'h1_0000},
    {16'h0000, 16'h0000, 17'h0_0000},
    {16'hFFFF, 16'hFFFF, 17'h1_FFFE},
    {16'h1234, 16'h4321, 17'h0_5555},
    {16'h8000, 16'h8000, 17'h1_0000},
    {16'hAAAA, 16'h5555, 17'h0_FFFF},
    {16'h00FF, 16'h0001, 17'h0_0100},
    {16'h7FFF, 16'h0001, 17'h0_8000},
    {16'hFFFE, 16'h0001, 17'h0_FFFF},
    {16'h0001, 16'hFFFF, 17'h1_0000}
  };

  logic [16:0] m_r [8];
  logic        m_v [8];
  logic [16:0] drv_exp = '0;
  logic [16:0] last_r = '0;
  bit          done = 0;

  task automatic check(input bit ok, input string req, input logic [16:0] act, input logic [16:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // one clock; model shifts at the edge, outputs sampled 2 ns later
  task automatic tick();
    @(posedge clk_i);
    if (!rst_ni) begin
      for (int i = 0; i < 8; i++) begin m_v[i] = 1'b0; m_r[i] = '0; end
      last_r = '0;
    end else begin
      for (int i = 7; i > 0; i--) begin m_v[i] = m_v[i-1]; m_r[i] = m_r[i-1]; end
      m_v[0] = valid_i;
      m_r[0] = drv_exp;
    end
    #2;
    check(valid_o == m_v[7], "R2 valid", {16'b0, valid_o}, {16'b0, m_v[7]});
    if (m_v[7]) begin
      check({cout_o, sum_o} == m_r[7], m_r[7][16] ? "R1/R3 sum+cout" : "R1/R6 sum",
            {cout_o, sum_o}, m_r[7]);
      last_r = m_r[7];
    end else begin
      check({cout_o, sum_o} == last_r, "R5 hold", {cout_o, sum_o}, last_r);
    end
  endtask

  task automatic drive(input logic v, input logic [15:0] a, input logic [15:0] b);
    valid_i = v; a_i = a; b_i = b;
    drv_exp = {1'b0, a} + {1'b0, b};
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_v[i] = 1'b0; m_r[i] = '0; end
    // R4: reset state with activity on inputs
    drive(1'b1, 16'hFFFF, 16'h0001);
    repeat (3) tick();
    check(!valid_o && sum_o == 0 && !cout_o, "R4 reset", {cout_o, sum_o}, 17'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(1'b0, 16'h0, 16'h0);
    repeat (3) tick();

    // table, back to back (R1, R2, R3, R6)
    for (int i = 0; i < NV; i++) begin
      valid_i = 1'b1; a_i = TBL[i][48:33]; b_i = TBL[i][32:17]; drv_exp = TBL[i][16:0];
      tick();
    end
    drive(1'b0, 16'h0, 16'h0);
    repeat (10) tick();

    // R5: bubbles carrying all-ones operands between valid pairs
    for (int i = 0; i < 12; i++) begin
      if (i % 3 == 0) drive(1'b1, 16'h0100 + 16'(i), 16'h0F00);
      else            drive(1'b0, 16'hFFFF, 16'hFFFF);
      tick();
    end
    drive(1'b0, 16'hFFFF, 16'hFFFF);
    repeat (10) tick();

    // random mix, mostly valid
    for (int i = 0; i < 300; i++) begin
      drive(($urandom % 4) != 0, 16'($urandom), 16'($urandom));
      tick();
    end

    // R7: reset with a full pipe
    for (int i = 0; i < 8; i++) begin
      drive(1'b1, 16'hFFFF, 16'(i + 1));
      tick();
    end
    #1 rst_ni = 1'b0;
    #1 check(!valid_o && sum_o == 0 && !cout_o, "R7/R4 async flush", {cout_o, sum_o}, 17'h0);
    drive(1'b0, 16'h0, 16'h0);
    tick();
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (10) tick();
    drive(1'b1, 16'hFFFF, 16'h0001);
    tick();
    drive(1'b0, 16'h0, 16'h0);
    repeat (10) tick();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule